// File: doc/BRIEF.md
# Eight-bit One-Shot Compare Timer

This block is an 8-bit up-counter that advances on a count-clock enable input. In one-shot mode it counts from zero to full scale, raises its overflow flag, and then stops with the counter held at full scale. Software clears the flag to run it again. With the mode bit low, the counter wraps and keeps running, and it still raises the overflow flag on each wrap. Two compare registers each drive an interrupt request pulse when the counter takes on their value.

Software uses a small register interface. Start, stop and rearm never change the counter in the same cycle as the register write. Each one is held as a pending request and takes effect on the next count-clock enable, however long that enable is in coming. The first such tick clears the counter to zero.

Top module: `oneshot_timer`

## Requirements
- R1: After reset the control word, both compare registers and the counter read zero, and both interrupt outputs are low.
- R2: Register addresses are 0 = control, 1 = compare A, 2 = compare B and 3 = counter (read-only). Reads are combinational on the current address. In the control word, bit 0 is enable, bit 5 selects one-shot mode and bit 6 is the overflow flag. All other bits read 0.
- R3: After enable is written from 0 to 1, the first tick loads the counter with 00H. Every later tick adds one.
- R4: In one-shot mode, the tick that brings the counter to FFH also sets the overflow flag. The counter then holds FFH while ticks continue.
- R5: Writing 0 to the overflow flag while enabled and halted in one-shot mode rearms the timer. The next tick loads 00H and counting resumes.
- R6: Writing enable to 0 makes the next tick clear the counter to 00H. The counter then stays there.
- R7: Writing enable as 1 when it is already 1 does not change counting.
- R8: A compare output goes high for exactly one clock, in the cycle after the tick that gives the counter its compare value. A load of 00H counts as taking a value. A counter that is held or cleared by a stop raises no pulse.
- R9: With one-shot mode off, a tick at FFH wraps the counter to 00H, sets the overflow flag, and counting goes on.
- R10: Software can clear the overflow flag but cannot set it. Writing 1 to the flag leaves it, and the halted counter, unchanged.
- R11: Without a tick the counter never changes. A pending start, stop or rearm waits through any number of idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntTick | input | 1 | Count-clock enable, one tick per high cycle |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for regAddr |
| irqA | output | 1 | Compare A interrupt pulse |
| irqB | output | 1 | Compare B interrupt pulse |

## Verification
A register write shows on the read port in the cycle after its clock edge. A tick changes the counter and the overflow flag at that same edge. The compare pulses are registered, so they are high for the whole cycle after their tick's edge. The bench drives stimulus on the falling edge and runs a behavioural model at each rising edge. It compares the model with the design 5 ns after that edge, so each result is read in the cycle where it first becomes valid. Spot checks are taken at the falling edge that closes a tick burst, which is when a pulse from the burst's last tick is showing.

// File: rtl/oneshot_timer_pkg.sv
package oneshot_timer_pkg;
  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic clrCnt;   // load zero
    logic incCnt;   // add one
    logic evalCmp;  // compare the new count value
  } cntStrobe_t;

  localparam int ADDR_CTL  = 0;
  localparam int ADDR_CMP0 = 1;
  localparam int ADDR_CNT  = 3;
  localparam int ENA_BIT   = 0;
  localparam int MODE_BIT  = 5;
  localparam int OVF_BIT   = 6;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import oneshot_timer_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int NUM_CMP = 2,
  parameter int ADDR_W  = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cntTick,
  input  logic                            regWe,
  input  logic [ADDR_W-1:0]               regAddr,
  input  logic [WIDTH-1:0]                regWdata,
  input  logic                            cntAtTop,
  input  logic                            cntNearTop,
  output cntStrobe_t                      strobe,
  output logic [WIDTH-1:0]                ctlWord,
  output logic [NUM_CMP-1:0][WIDTH-1:0]   cmpVal,
  output logic                            enable,
  output logic                            modeOneShot,
  output logic                            ovfFlag,
  output logic                            pendClear,
  output logic                            pendStop
);
  logic ctlWr;
  logic running;
  logic wrapSet;
  logic newEna;

  assign ctlWr   = regWe && (regAddr == ADDR_W'(ADDR_CTL));
  assign newEna  = regWdata[ENA_BIT];
  assign running = enable && !(modeOneShot && ovfFlag);

  always_comb begin
    strobe = '0;
    if (cntTick) begin
      if (pendStop) begin
        strobe.clrCnt = 1'b1;
      end else if (enable && pendClear) begin
        strobe.clrCnt  = 1'b1;
        strobe.evalCmp = 1'b1;
      end else if (running) begin
        strobe.incCnt  = 1'b1;
        strobe.evalCmp = 1'b1;
      end
    end
  end

  assign wrapSet = strobe.incCnt && (modeOneShot ? cntNearTop : cntAtTop);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable      <= 1'b0;
      modeOneShot <= 1'b0;
      ovfFlag     <= 1'b0;
      pendClear   <= 1'b0;
      pendStop    <= 1'b0;
    end else begin
      if (strobe.clrCnt) begin
        pendClear <= 1'b0;
        pendStop  <= 1'b0;
      end
      if (wrapSet) ovfFlag <= 1'b1;
      if (ctlWr) begin
        enable      <= newEna;
        modeOneShot <= regWdata[MODE_BIT];
        if (!regWdata[OVF_BIT] && !wrapSet) ovfFlag <= 1'b0;
        if (newEna && !enable) begin
          pendClear <= 1'b1;
          pendStop  <= 1'b0;
        end else if (!newEna && enable) begin
          pendStop  <= 1'b1;
          pendClear <= 1'b0;
        end else if (newEna && regWdata[MODE_BIT] && ovfFlag && !regWdata[OVF_BIT]) begin
          pendClear <= 1'b1;
        end
      end
    end
  end

  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmpReg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpVal[gi] <= '0;
      end else if (regWe && (regAddr == ADDR_W'(ADDR_CMP0 + gi))) begin
        cmpVal[gi] <= regWdata;
      end
    end
  end

  always_comb begin
    ctlWord           = '0;
    ctlWord[ENA_BIT]  = enable;
    ctlWord[MODE_BIT] = modeOneShot;
    ctlWord[OVF_BIT]  = ovfFlag;
  end
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import oneshot_timer_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int NUM_CMP = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  cntStrobe_t                    strobe,
  input  logic [NUM_CMP-1:0][WIDTH-1:0] cmpVal,
  output logic [WIDTH-1:0]              cntVal,
  output logic                          cntAtTop,
  output logic                          cntNearTop,
  output logic [NUM_CMP-1:0]            irqVec
);
  localparam logic [WIDTH-1:0] TOP_VAL  = '1;
  localparam logic [WIDTH-1:0] NEAR_VAL = TOP_VAL - WIDTH'(1);

  logic [WIDTH-1:0] nextVal;

  assign nextVal    = strobe.clrCnt ? '0 : cntVal + WIDTH'(1);
  assign cntAtTop   = (cntVal == TOP_VAL);
  assign cntNearTop = (cntVal == NEAR_VAL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (strobe.clrCnt || strobe.incCnt) begin
      cntVal <= nextVal;
    end
  end

  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_match
    always_ff @(posedge clk) begin
      if (!rstN) irqVec[gi] <= 1'b0;
      else       irqVec[gi] <= strobe.evalCmp && (nextVal == cmpVal[gi]);
    end
  end
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_timer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntTick,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [WIDTH-1:0] regWdata,
  output logic [WIDTH-1:0] regRdata,
  output logic             irqA,
  output logic             irqB
);
  localparam int NUM_CMP = 2;
  localparam int ADDR_W  = 2;

  cntStrobe_t                    strobe;
  logic [WIDTH-1:0]              ctlWord;
  logic [NUM_CMP-1:0][WIDTH-1:0] cmpVal;
  logic [WIDTH-1:0]              cntVal;
  logic                          cntAtTop;
  logic                          cntNearTop;
  logic [NUM_CMP-1:0]            irqVec;
  logic                          enable;
  logic                          modeOneShot;
  logic                          ovfFlag;
  logic                          pendClear;
  logic                          pendStop;

  timer_ctrl #(.WIDTH(WIDTH), .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .cntAtTop(cntAtTop),
    .cntNearTop(cntNearTop), .strobe(strobe), .ctlWord(ctlWord),
    .cmpVal(cmpVal), .enable(enable), .modeOneShot(modeOneShot),
    .ovfFlag(ovfFlag), .pendClear(pendClear), .pendStop(pendStop)
  );

  timer_datapath #(.WIDTH(WIDTH), .NUM_CMP(NUM_CMP)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpVal(cmpVal),
    .cntVal(cntVal), .cntAtTop(cntAtTop), .cntNearTop(cntNearTop),
    .irqVec(irqVec)
  );

  always_comb begin
    case (regAddr)
      2'd0:    regRdata = ctlWord;
      2'd1:    regRdata = cmpVal[0];
      2'd2:    regRdata = cmpVal[1];
      default: regRdata = cntVal;
    endcase
  end

  assign irqA = irqVec[0];
  assign irqB = irqVec[1];
endmodule

// File: rtl/timer_checker.sv
module timer_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntTick,
  input logic [WIDTH-1:0] count,
  input logic [WIDTH-1:0] cmpA,
  input logic [WIDTH-1:0] cmpB,
  input logic             mode,
  input logic             ovf,
  input logic             pendClear,
  input logic             pendStop,
  input logic             irqA,
  input logic             irqB
);
  localparam logic [WIDTH-1:0] FULL = '1;

  AST_IRQA_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqA |=> !irqA); // R8
  AST_IRQB_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqB |=> !irqB); // R8
  AST_IRQA_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    irqA |-> (count == $past(cmpA))); // R8
  AST_IRQB_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    irqB |-> (count == $past(cmpB))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cntTick |=> $stable(count)); // R11
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (mode && ovf && count == FULL && !pendClear && !pendStop) |=> (count == FULL)); // R4
  AST_OVF_AT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ovf) && $past(mode)) |-> (count == FULL)); // R4
  AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pendStop) && $past(cntTick)) |-> (count == '0 && !irqA && !irqB)); // R6
endmodule

bind oneshot_timer timer_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .cntTick(cntTick), .count(cntVal),
  .cmpA(cmpVal[0]), .cmpB(cmpVal[1]), .mode(modeOneShot), .ovf(ovfFlag),
  .pendClear(pendClear), .pendStop(pendStop), .irqA(irqA), .irqB(irqB)
);

// File: tb/test_oneshot_timer.sv
module test_oneshot_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cntTick = 1'b0;
  logic       regWe = 1'b0;
  logic [1:0] regAddr = 2'd3;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       irqA, irqB;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit mEn, mMode, mOvf, mPClr, mPStop, eIrqA, eIrqB;
  int mCnt, mCmpA, mCmpB;

  oneshot_timer i_oneshot_timer (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .irqA(irqA), .irqB(irqB)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] modelRead(input logic [1:0] a);
    case (a)
      2'd0:    return {1'b0, mOvf, mMode, 4'b0, mEn};
      2'd1:    return mCmpA[7:0];
      2'd2:    return mCmpB[7:0];
      default: return mCnt[7:0];
    endcase
  endfunction

  always @(posedge clk) begin
    bit oEn, oOvf, hwSet, nEn;
    if (!rstN) begin
      mEn = 0; mMode = 0; mOvf = 0; mPClr = 0; mPStop = 0;
      mCnt = 0; mCmpA = 0; mCmpB = 0; eIrqA = 0; eIrqB = 0;
    end else begin
      oEn = mEn; oOvf = mOvf; hwSet = 0;
      eIrqA = 0; eIrqB = 0;
      if (cntTick) begin
        if (mPStop) begin
          mCnt = 0; mPStop = 0; mPClr = 0;
        end else if (mEn && mPClr) begin
          mCnt = 0; mPClr = 0;
          eIrqA = (mCmpA == 0); eIrqB = (mCmpB == 0);
        end else if (mEn && !(mMode && mOvf)) begin
          mCnt = (mCnt + 1) % 256;
          if (mMode ? (mCnt == 255) : (mCnt == 0)) begin mOvf = 1; hwSet = 1; end
          eIrqA = (mCnt == mCmpA); eIrqB = (mCnt == mCmpB);
        end
      end
      if (regWe) begin
        case (regAddr)
          2'd0: begin
            nEn = regWdata[0];
            if (nEn && !oEn) begin mPClr = 1; mPStop = 0; end
            else if (!nEn && oEn) begin mPStop = 1; mPClr = 0; end
            else if (nEn && regWdata[5] && oOvf && !regWdata[6]) mPClr = 1;
            if (!regWdata[6] && !hwSet) mOvf = 0;
            mEn = nEn; mMode = regWdata[5];
          end
          2'd1: mCmpA = regWdata;
          2'd2: mCmpB = regWdata;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, 5 ns after the active edge
  always @(posedge clk) begin
    #5;
    if (rstN) begin
      checks++;
      if (irqA !== eIrqA) begin errors++; $display("FAIL R8 irqA act %0b exp %0b", irqA, eIrqA); end
      checks++;
      if (irqB !== eIrqB) begin errors++; $display("FAIL R8 irqB act %0b exp %0b", irqB, eIrqB); end
      checks++;
      if (regRdata !== modelRead(regAddr)) begin
        errors++;
        $display("FAIL R3 readback addr %0d act %02h exp %02h", regAddr, regRdata, modelRead(regAddr));
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0; regAddr = 2'd3;
  endtask

  task automatic tk(input int n);
    @(negedge clk); cntTick = 1'b1;
    repeat (n) @(negedge clk);
    cntTick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectReg(input logic [1:0] a, input logic [7:0] e, input string tag);
    regAddr = a; #2;
    checks++;
    if (regRdata !== e) begin
      errors++;
      $display("FAIL %s addr %0d act %02h exp %02h", tag, a, regRdata, e);
    end
    regAddr = 2'd3;
  endtask

  task automatic expectBit(input logic act, input logic e, input string tag);
    checks++;
    if (act !== e) begin errors++; $display("FAIL %s act %0b exp %0b", tag, act, e); end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    expectReg(2'd0, 8'h00, "R1 ctl");
    expectReg(2'd1, 8'h00, "R1 cmpA");
    expectReg(2'd2, 8'h00, "R1 cmpB");
    expectReg(2'd3, 8'h00, "R1 count");
    expectBit(irqA | irqB, 1'b0, "R1 irq");

    wr(2'd1, 8'h03);
    wr(2'd2, 8'h00);
    expectReg(2'd1, 8'h03, "R2 cmpA");
    expectReg(2'd2, 8'h00, "R2 cmpB");
    wr(2'd0, 8'h21);
    expectReg(2'd0, 8'h21, "R2 ctl");
    idle(3);
    expectReg(2'd3, 8'h00, "R11 no tick");
    tk(1);
    expectReg(2'd3, 8'h00, "R3 first tick loads 00");
    expectBit(irqB, 1'b1, "R8 load match 00");
    tk(3);
    expectReg(2'd3, 8'h03, "R3 increments");
    expectBit(irqA, 1'b1, "R8 match cmpA");
    idle(5);
    expectReg(2'd3, 8'h03, "R11 idle hold");
    wr(2'd0, 8'h21);
    tk(1);
    expectReg(2'd3, 8'h04, "R7 rewrite enable");
    wr(2'd2, 8'hFF);
    tk(251);
    expectReg(2'd3, 8'hFF, "R4 reach full");
    expectReg(2'd0, 8'h61, "R4 ovf set");
    expectBit(irqB, 1'b1, "R8 match at FF");
    tk(5);
    expectReg(2'd3, 8'hFF, "R4 hold full");
    expectBit(irqB, 1'b0, "R8 no repeat at hold");
    wr(2'd0, 8'h61);
    expectReg(2'd0, 8'h61, "R10 ovf write 1");
    tk(2);
    expectReg(2'd3, 8'hFF, "R10 still halted");
    wr(2'd0, 8'h21);
    expectReg(2'd0, 8'h21, "R5 ovf cleared");
    idle(4);
    expectReg(2'd3, 8'hFF, "R11 rearm pending");
    tk(1);
    expectReg(2'd3, 8'h00, "R5 rearm load");
    tk(2);
    expectReg(2'd3, 8'h02, "R5 resumes");
    wr(2'd0, 8'h20);
    expectReg(2'd3, 8'h02, "R6 no change before tick");
    tk(1);
    expectReg(2'd3, 8'h00, "R6 stop clears");
    tk(4);
    expectReg(2'd3, 8'h00, "R6 stays stopped");
    wr(2'd0, 8'h01);
    tk(1);
    expectReg(2'd3, 8'h00, "R3 free start");
    tk(255);
    expectReg(2'd3, 8'hFF, "R9 at full");
    expectReg(2'd0, 8'h01, "R9 no ovf yet");
    tk(1);
    expectReg(2'd3, 8'h00, "R9 wrap");
    expectReg(2'd0, 8'h41, "R9 ovf on wrap");
    tk(3);
    expectReg(2'd3, 8'h03, "R9 keeps counting");
    expectBit(irqA, 1'b1, "R8 match after wrap");
    wr(2'd0, 8'h01);
    expectReg(2'd0, 8'h01, "R9 ovf clear free mode");
    tk(1);
    expectReg(2'd3, 8'h04, "R9 no rearm in free mode");
    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act timeout exp finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule